// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the software-facing register port of one eight-line interrupt controller. It has a byte-wide data path and a single address bit. Writes are sorted into three kinds: a start-of-setup word that restarts the controller, the setup words that follow it, and operational commands. The operational commands are end-of-interrupt variants, priority rotation, read selection and poll. Reads return the request vector, the in-service vector, the mask, or a poll answer.

The request and in-service vectors live in a separate resolver core and reach this block as inputs. The block tells the core which bits to drop through one-cycle clear strobes, and it drives a restart strobe. It owns the mask, the vector base, the rotating priority base and the mode flags, and exports them to the core. Priority is circular: rank 0 is the line equal to the priority base, and rank increases with the line number modulo 8.

Top module: `irqc_cmd_port`

## Requirements
- R1: After reset, rdata, mask_o, vbase_o, prio_base_o, all mode flags and all strobes are 0, and reads at address 0 select the request vector.
- R2: A write to address 0 with wdata[4]=1 pulses init_pulse for the next cycle. It also zeroes the mask, vector base, priority base, nested and auto-EOI flags, rotate flag, special mask and poll flag, and it resets read selection to the request vector.
- R3: The first address-1 write after that start word stores wdata & 8'hF8 in vbase_o and leaves the mask unchanged.
- R4: The second address-1 write after the start word has no effect. A third address-1 write follows only if wdata[0] of the start word was 1. That third write sets nested_o from wdata[4] and auto_eoi_o from wdata[1], and it leaves the mask unchanged.
- R5: Outside the setup sequence, an address-1 write loads mask_o, and mask_o changes on no other write.
- R6: An address-0 write with wdata[4]=0 and wdata[3]=1 is a read-control word. wdata[2]=1 arms poll. If wdata[1]=1, wdata[0] selects the in-service vector (1) or the request vector (0); otherwise the selection is kept. If wdata[6]=1, spec_mask_o takes wdata[5]; otherwise it is kept.
- R7: An address-0 write with wdata[4:3]=0 is a command with code wdata[7:5]. Code 0 clears rot_aeoi_o and code 4 sets it.
- R8: Code 1 pulses isr_clr for one cycle, one-hot on the in-service line of best rank, or all zeros if isr_vec is 0. Code 5 does the same and also sets prio_base_o to that line + 1 mod 8.
- R9: Code 3 pulses isr_clr on line wdata[2:0]. Code 7 does the same and also sets prio_base_o to wdata[2:0]+1 mod 8. Code 6 sets prio_base_o to wdata[2:0]+1 mod 8. Code 2 changes nothing.
- R10: When poll is not armed, a read registers rdata on the next cycle. At address 0 rdata is isr_vec or req_vec, according to the selection. At address 1 it is mask_o.
- R11: When poll is armed, a read at either address disarms it. If an unmasked request has a better rank than every in-service line, rdata is that line, and req_clr and isr_clr pulse one-hot on it. Otherwise rdata is 7 and both strobes stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| req_vec | input | 8 | Request vector from the core |
| isr_vec | input | 8 | In-service vector from the core |
| rdata | output | 8 | Registered read data |
| mask_o | output | 8 | Line mask |
| vbase_o | output | 8 | Vector base (low three bits zero) |
| prio_base_o | output | 3 | Line holding rank 0 |
| nested_o | output | 1 | Nested-mode flag |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt flag |
| rot_aeoi_o | output | 1 | Rotate-on-automatic-EOI flag |
| spec_mask_o | output | 1 | Special mask flag |
| init_pulse | output | 1 | Restart strobe to the core |
| isr_clr | output | 8 | One-cycle in-service clear strobe |
| req_clr | output | 8 | One-cycle request clear strobe |

## Verification
On every cycle the assertions check the following. The restart strobe always follows a start word and coincides with cleared state. The mask moves only after a write, and read data moves only after a read. A poll clear is one-hot and always paired with the same in-service clear. Only the bench scenarios show the values themselves: which line a rotated end-of-interrupt picks, the vector base masking, whether the setup word is skipped or taken, selection persistence, and poll answers when the request is blocked or masked.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NL = 8;
  localparam int LW = $clog2(NL);
  localparam logic [LW:0] NO_RANK = (LW+1)'(NL);

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_VBASE = 2'd1,
    ST_SKIP = 2'd2,
    ST_MODE = 2'd3
  } init_st_t;

  // Best (lowest) rank of a set bit when rank 0 sits at line 'base'.
  function automatic logic [LW:0] best_rank(input logic [NL-1:0] v,
                                            input logic [LW-1:0] base);
    logic [LW:0] r;
    r = NO_RANK;
    for (int i = NL-1; i >= 0; i--) begin
      if (v[base + LW'(i)]) r = (LW+1)'(i);
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] rank_line(input logic [LW:0] r,
                                              input logic [LW-1:0] base);
    return r[LW-1:0] + base;
  endfunction

  function automatic logic [NL-1:0] line_bit(input logic [LW-1:0] l);
    return NL'(1) << l;
  endfunction
endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [NL-1:0] wdata,
  output logic          init_hit,
  output logic [NL-1:0] mask_q,
  output logic [NL-1:0] vbase_q,
  output logic          nested_q,
  output logic          aeoi_q,
  output logic          init_pulse_q
);
  init_st_t st_q;
  logic     want_mode_q;
  logic     wr_hi;

  assign init_hit = wr_en && !addr && wdata[4];
  assign wr_hi    = wr_en && addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_RUN;
      want_mode_q  <= 1'b0;
      mask_q       <= '0;
      vbase_q      <= '0;
      nested_q     <= 1'b0;
      aeoi_q       <= 1'b0;
      init_pulse_q <= 1'b0;
    end else begin
      init_pulse_q <= init_hit;
      if (init_hit) begin
        st_q        <= ST_VBASE;
        want_mode_q <= wdata[0];
        mask_q      <= '0;
        vbase_q     <= '0;
        nested_q    <= 1'b0;
        aeoi_q      <= 1'b0;
      end else if (wr_hi) begin
        unique case (st_q)
          ST_RUN:   mask_q <= wdata;
          ST_VBASE: begin
            vbase_q <= wdata & 8'hF8;
            st_q    <= ST_SKIP;
          end
          ST_SKIP:  st_q <= want_mode_q ? ST_MODE : ST_RUN;
          ST_MODE:  begin
            nested_q <= wdata[4];
            aeoi_q   <= wdata[1];
            st_q     <= ST_RUN;
          end
          default:  st_q <= ST_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_op_decode.sv
module irqc_op_decode
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [NL-1:0] wdata,
  input  logic          init_hit,
  input  logic          poll_taken,
  input  logic [NL-1:0] isr_vec,
  output logic [LW-1:0] prio_base_q,
  output logic          rot_aeoi_q,
  output logic          sel_isr_q,
  output logic          spec_mask_q,
  output logic          poll_q,
  output logic [NL-1:0] eoi_clr
);
  logic          cmd_wr, rdc_wr;
  logic [2:0]    code;
  logic [LW:0]   isr_rank;
  logic [LW-1:0] isr_line, cmd_line;

  assign cmd_wr   = wr_en && !addr && !wdata[4] && !wdata[3];
  assign rdc_wr   = wr_en && !addr && !wdata[4] &&  wdata[3];
  assign code     = wdata[7:5];
  assign cmd_line = wdata[LW-1:0];
  assign isr_rank = best_rank(isr_vec, prio_base_q);
  assign isr_line = rank_line(isr_rank, prio_base_q);

  always_comb begin
    eoi_clr = '0;
    if (cmd_wr) begin
      unique case (code)
        3'd1, 3'd5: if (isr_rank != NO_RANK) eoi_clr = line_bit(isr_line);
        3'd3, 3'd7: eoi_clr = line_bit(cmd_line);
        default:    eoi_clr = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_base_q <= '0;
      rot_aeoi_q  <= 1'b0;
      sel_isr_q   <= 1'b0;
      spec_mask_q <= 1'b0;
      poll_q      <= 1'b0;
    end else if (init_hit) begin
      prio_base_q <= '0;
      rot_aeoi_q  <= 1'b0;
      sel_isr_q   <= 1'b0;
      spec_mask_q <= 1'b0;
      poll_q      <= 1'b0;
    end else begin
      if (poll_taken) poll_q <= 1'b0;
      if (rdc_wr) begin
        if (wdata[2]) poll_q      <= 1'b1;
        if (wdata[1]) sel_isr_q   <= wdata[0];
        if (wdata[6]) spec_mask_q <= wdata[5];
      end
      if (cmd_wr) begin
        unique case (code)
          3'd0, 3'd4: rot_aeoi_q <= code[2];
          3'd5: if (isr_rank != NO_RANK) prio_base_q <= isr_line + LW'(1);
          3'd6, 3'd7: prio_base_q <= cmd_line + LW'(1);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_read_port.sv
module irqc_read_port
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          addr,
  input  logic          poll_q,
  input  logic          sel_isr,
  input  logic [LW-1:0] prio_base,
  input  logic [NL-1:0] req_vec,
  input  logic [NL-1:0] isr_vec,
  input  logic [NL-1:0] mask,
  output logic          poll_taken,
  output logic [NL-1:0] poll_clr,
  output logic [NL-1:0] rdata_q
);
  logic [LW:0]   req_rank, cur_rank;
  logic [LW-1:0] win_line;
  logic          win;

  assign req_rank   = best_rank(req_vec & ~mask, prio_base);
  assign cur_rank   = best_rank(isr_vec, prio_base);
  assign win        = (req_rank != NO_RANK) && (req_rank < cur_rank);
  assign win_line   = rank_line(req_rank, prio_base);
  assign poll_taken = rd_en && poll_q;
  assign poll_clr   = (poll_taken && win) ? line_bit(win_line) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      if (poll_q)       rdata_q <= win ? NL'(win_line) : NL'(7);
      else if (addr)    rdata_q <= mask;
      else if (sel_isr) rdata_q <= isr_vec;
      else              rdata_q <= req_vec;
    end
  end
endmodule

// File: rtl/irqc_cmd_port.sv
module irqc_cmd_port
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [7:0]    wdata,
  input  logic [7:0]    req_vec,
  input  logic [7:0]    isr_vec,
  output logic [7:0]    rdata,
  output logic [7:0]    mask_o,
  output logic [7:0]    vbase_o,
  output logic [2:0]    prio_base_o,
  output logic          nested_o,
  output logic          auto_eoi_o,
  output logic          rot_aeoi_o,
  output logic          spec_mask_o,
  output logic          init_pulse,
  output logic [7:0]    isr_clr,
  output logic [7:0]    req_clr
);
  logic          init_hit, poll_taken, poll_q, sel_isr;
  logic [NL-1:0] eoi_clr, poll_clr;

  irqc_init_seq u_init (
    .clk, .rst_n, .wr_en, .addr, .wdata,
    .init_hit     (init_hit),
    .mask_q       (mask_o),
    .vbase_q      (vbase_o),
    .nested_q     (nested_o),
    .aeoi_q       (auto_eoi_o),
    .init_pulse_q (init_pulse)
  );

  irqc_op_decode u_op (
    .clk, .rst_n, .wr_en, .addr, .wdata,
    .init_hit    (init_hit),
    .poll_taken  (poll_taken),
    .isr_vec     (isr_vec),
    .prio_base_q (prio_base_o),
    .rot_aeoi_q  (rot_aeoi_o),
    .sel_isr_q   (sel_isr),
    .spec_mask_q (spec_mask_o),
    .poll_q      (poll_q),
    .eoi_clr     (eoi_clr)
  );

  irqc_read_port u_rd (
    .clk, .rst_n, .rd_en, .addr,
    .poll_q     (poll_q),
    .sel_isr    (sel_isr),
    .prio_base  (prio_base_o),
    .req_vec    (req_vec),
    .isr_vec    (isr_vec),
    .mask       (mask_o),
    .poll_taken (poll_taken),
    .poll_clr   (poll_clr),
    .rdata_q    (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_clr <= '0;
      req_clr <= '0;
    end else begin
      isr_clr <= eoi_clr | poll_clr;
      req_clr <= poll_clr;
    end
  end
endmodule

// File: rtl/irqc_cmd_port_chk.sv
module irqc_cmd_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] mask_o,
  input logic [2:0] prio_base_o,
  input logic       nested_o,
  input logic       auto_eoi_o,
  input logic       init_pulse,
  input logic [7:0] isr_clr,
  input logic [7:0] req_clr
);
  assert_init_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> init_pulse);

  assert_init_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |-> (mask_o == 8'h00 && prio_base_o == 3'd0 && !nested_o && !auto_eoi_o));

  assert_mask_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_o) |-> $past(wr_en));

  assert_rdata_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(rd_en));

  assert_poll_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_clr));

  assert_poll_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr != 8'h00) |-> ((req_clr & isr_clr) == req_clr));
endmodule

bind irqc_cmd_port irqc_cmd_port_chk u_chk (
  .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .mask_o,
  .prio_base_o, .nested_o, .auto_eoi_o, .init_pulse, .isr_clr, .req_clr
);

// File: tb/irqc_cmd_port_tb.sv
`timescale 1ns/1ps
module irqc_cmd_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, req_vec = '0, isr_vec = '0;
  logic [7:0] rdata, mask_o, vbase_o, isr_clr, req_clr;
  logic [2:0] prio_base_o;
  logic       nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, init_pulse;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irqc_cmd_port u_dut (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .req_vec, .isr_vec,
    .rdata, .mask_o, .vbase_o, .prio_base_o, .nested_o, .auto_eoi_o,
    .rot_aeoi_o, .spec_mask_o, .init_pulse, .isr_clr, .req_clr
  );

  // {preset base, isr_vec, command, expected isr_clr, expected base}
  localparam logic [29:0] EOI_TBL [9] = '{
    {3'd0, 8'h0A, 8'h20, 8'h02, 3'd0},
    {3'd2, 8'h0A, 8'h20, 8'h08, 3'd2},
    {3'd4, 8'h0A, 8'hA0, 8'h02, 3'd2},
    {3'd0, 8'h00, 8'h20, 8'h00, 3'd0},
    {3'd0, 8'h80, 8'h65, 8'h20, 3'd0},
    {3'd3, 8'h00, 8'hE6, 8'h40, 3'd7},
    {3'd0, 8'h00, 8'hC4, 8'h00, 3'd5},
    {3'd5, 8'hFF, 8'h40, 8'h00, 3'd5},
    {3'd7, 8'h81, 8'h20, 8'h80, 3'd7}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", rdata, 8'h00);
    check("R1 mask", mask_o, 8'h00);
    check("R1 base", {5'd0, prio_base_o}, 8'h00);
    check("R1 flags", {nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, init_pulse}, 8'h00);
    check("R1 strobes", isr_clr | req_clr, 8'h00);

    // End-of-interrupt and rotation commands
    for (int i = 0; i < 9; i++) begin
      logic [2:0] b;
      b = EOI_TBL[i][29:27];
      isr_vec = EOI_TBL[i][26:19];
      wr(1'b0, 8'hC0 | {5'd0, b - 3'd1});
      wr(1'b0, EOI_TBL[i][18:11]);
      check($sformatf("R8 R9 entry %0d clear", i), isr_clr, EOI_TBL[i][10:3]);
      check($sformatf("R8 R9 entry %0d base", i), {5'd0, prio_base_o}, {5'd0, EOI_TBL[i][2:0]});
    end

    wr(1'b0, 8'h80);
    check("R7 rotate set", {7'd0, rot_aeoi_o}, 8'h01);
    wr(1'b0, 8'h00);
    check("R7 rotate clear", {7'd0, rot_aeoi_o}, 8'h00);

    // Setup without the mode word
    wr(1'b0, 8'h10);
    check("R2 init pulse", {7'd0, init_pulse}, 8'h01);
    check("R2 base cleared", {5'd0, prio_base_o}, 8'h00);
    wr(1'b1, 8'h6B);
    check("R2 pulse single", {7'd0, init_pulse}, 8'h00);
    check("R3 vector base", vbase_o, 8'h68);
    check("R3 mask kept", mask_o, 8'h00);
    wr(1'b1, 8'h55);
    check("R4 skip word", mask_o, 8'h00);
    wr(1'b1, 8'h3C);
    check("R4 no mode word", {6'd0, nested_o, auto_eoi_o}, 8'h00);
    check("R5 mask load", mask_o, 8'h3C);

    // Setup with the mode word
    req_vec = 8'h35; isr_vec = 8'h42;
    wr(1'b0, 8'hC2);
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h68);
    wr(1'b0, 8'h11);
    check("R2 mask cleared", mask_o, 8'h00);
    check("R2 spec cleared", {7'd0, spec_mask_o}, 8'h00);
    rd(1'b0);
    check("R2 select reset", rdata, 8'h35);
    wr(1'b1, 8'h20);
    check("R3 vector base 2", vbase_o, 8'h20);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h12);
    check("R4 mode word", {6'd0, nested_o, auto_eoi_o}, 8'h03);
    check("R4 mode mask kept", mask_o, 8'h00);
    wr(1'b1, 8'hA5);
    check("R5 mask after mode", mask_o, 8'hA5);

    // Read selection and special mask
    wr(1'b0, 8'h0B);
    rd(1'b0);
    check("R6 R10 select isr", rdata, 8'h42);
    wr(1'b0, 8'h09);
    rd(1'b0);
    check("R6 select kept", rdata, 8'h42);
    wr(1'b0, 8'h0A);
    rd(1'b0);
    check("R10 select req", rdata, 8'h35);
    rd(1'b1);
    check("R10 mask read", rdata, 8'hA5);
    wr(1'b0, 8'h68);
    check("R6 spec set", {7'd0, spec_mask_o}, 8'h01);
    wr(1'b0, 8'h28);
    check("R6 spec kept", {7'd0, spec_mask_o}, 8'h01);
    wr(1'b0, 8'h48);
    check("R6 spec clear", {7'd0, spec_mask_o}, 8'h00);

    // Poll
    wr(1'b1, 8'h00);
    req_vec = 8'h30; isr_vec = 8'h00;
    wr(1'b0, 8'h0C);
    rd(1'b0);
    check("R11 poll line", rdata, 8'h04);
    check("R11 poll req clr", req_clr, 8'h10);
    check("R11 poll isr clr", isr_clr, 8'h10);
    rd(1'b0);
    check("R11 poll disarmed", rdata, 8'h30);
    check("R11 strobe ends", req_clr, 8'h00);
    isr_vec = 8'h04;
    wr(1'b0, 8'h0C);
    rd(1'b1);
    check("R11 poll blocked", rdata, 8'h07);
    check("R11 blocked no clr", req_clr | isr_clr, 8'h00);
    isr_vec = 8'h40;
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h0C);
    rd(1'b0);
    check("R11 poll masked", rdata, 8'h05);
    check("R11 masked clr", req_clr, 8'h20);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hC5);
    req_vec = 8'h03; isr_vec = 8'h00;
    wr(1'b0, 8'h0C);
    rd(1'b0);
    check("R11 poll rotated", rdata, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule